// File: doc/BRIEF.md
# Dual-Role SPI Byte Controller

This block moves one byte at a time over a four-wire SPI link and can act either as the clock-driving master or as a selected slave. A mode bit in the control register picks the role. Software drives it through a small register port with three registers: control, status and data. In either role each transfer exchanges the contents of the local shift register with those of the far-end device. When a byte is done the block raises a completion flag and, if enabled, an interrupt request. It also drives four outputs that tell the pad logic which pins it forces to input.

As master, writing the data register starts an internal divider that produces eight SCK pulses. The clock rate is the system clock divided by a power of two between 4 and 128. As slave, the block shifts on SCK pulses from outside. It takes part only while its active-low select input is held low. It brings SCK, select and MOSI into the system clock domain through two flip-flops. Timing is fixed to SPI mode 0 and data goes MSB first. The receive side keeps the last finished byte in a buffer. The transmit side has no buffer.

Top module: `spi_dual_role`

## Requirements
- R1: As master, a data-register write with the block enabled produces exactly eight SCK pulses. SCK sits low when idle and each pulse lasts 4<<r system clocks, where r is control bits [2:0]. A value of r above 5 acts as 5, which gives divide-by-128.
- R2: The first data bit goes out as the MSB. MOSI (master) or MISO (slave) changes only after a falling SCK edge and stays stable while SCK is high. The incoming bit is sampled on the rising edge.
- R3: After the eighth bit the master clock stops and status bit 7 (done) is set.
- R4: irq is high exactly while done is set and control bit 7 (interrupt enable) is 1.
- R5: Each transfer swaps the bytes. The byte received goes into the read buffer, returned by a data-register read (address 2). It also replaces the local shift register contents, which become the next byte sent if no new byte is written.
- R6: A data write while a shift is in progress does not change the outgoing byte or the transfer. It sets status bit 6 (write collision).
- R7: Done and write collision are cleared only by a status read (address 1) that sees them set, followed by a data-register access. A data access with no status read before it leaves them set.
- R8: The read buffer keeps the previous byte while the next one shifts in. A byte that is never read is overwritten by the next completed byte.
- R9: In slave mode (control bit 4 = 0, bit 6 = 1) SCK edges are ignored while the select input is high. A byte completes only after eight SCK pulses with select low.
- R10: Direction overrides: with the block enabled as master, only force_in_miso is 1. Enabled as slave, force_in_mosi, force_in_sck and force_in_ss are 1 and force_in_miso is 0. Disabled (control bit 6 = 0), all four are 0.
- R11: With the block disabled, a data-register write starts nothing and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (status/data side effects) |
| bus_addr | input | 2 | 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from the far-end master |
| sck_o | output | 1 | Serial clock generated in master mode |
| mosi_i | input | 1 | Serial data in, slave mode |
| mosi_o | output | 1 | Serial data out, master mode |
| miso_i | input | 1 | Serial data in, master mode |
| miso_o | output | 1 | Serial data out, slave mode |
| ss_n_i | input | 1 | Active-low slave select |
| force_in_mosi | output | 1 | MOSI pad forced to input |
| force_in_miso | output | 1 | MISO pad forced to input |
| force_in_sck | output | 1 | SCK pad forced to input |
| force_in_ss | output | 1 | Select pad forced to input |

## Verification
The hardest state to reach is a second data write that lands inside a live master shift. It has to hit the window between two SCK edges and then be shown to leave the outgoing bit stream untouched. The bench issues that write a few clocks into the transfer. A behavioural model tracks the elapsed time and predicts SCK and MOSI for every clock, so any disturbance to the running byte shows up at once. The overrun case is reached by running back-to-back transfers with no read between them. The ignored-select case is reached by toggling SCK with select high. The later transfer with select low then shows the bit counter never moved.

// File: rtl/spi_dual_role.sv
module spi_dual_role #(
  parameter int DW       = 8,
  parameter int MAX_RATE = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  input  logic          sck_i,
  output logic          sck_o,
  input  logic          mosi_i,
  output logic          mosi_o,
  input  logic          miso_i,
  output logic          miso_o,
  input  logic          ss_n_i,
  output logic          force_in_mosi,
  output logic          force_in_miso,
  output logic          force_in_sck,
  output logic          force_in_ss
);
  localparam int CW   = $clog2(DW);
  localparam int DIVW = MAX_RATE + 2;

  logic          ie, en, mst;
  logic [2:0]    rate;
  logic [DW-1:0] shreg, rx_q;
  logic          done_q, wcol_q, arm_d, arm_w;

  wire wr_ctl  = bus_sel & bus_wr & (bus_addr == 2'd0);
  wire rd_stat = bus_sel & bus_rd & (bus_addr == 2'd1);
  wire wr_data = bus_sel & bus_wr & (bus_addr == 2'd2);
  wire acc_dat = bus_sel & (bus_wr | bus_rd) & (bus_addr == 2'd2);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ie <= 1'b0; en <= 1'b0; mst <= 1'b0; rate <= '0;
    end else if (wr_ctl) begin
      ie <= bus_wdata[7]; en <= bus_wdata[6]; mst <= bus_wdata[4]; rate <= bus_wdata[2:0];
    end

  // master clock generator
  wire [2:0]      rate_eff = (rate > 3'(MAX_RATE)) ? 3'(MAX_RATE) : rate;
  wire [DIVW-1:0] half_m1  = (DIVW'(2) << rate_eff) - DIVW'(1);
  logic [DIVW-1:0] m_div;
  logic [CW-1:0]   m_bits;
  logic            m_busy, sck_q, m_samp;

  wire m_tick = m_busy & (m_div == half_m1);
  wire m_rise = m_tick & ~sck_q;
  wire m_fall = m_tick & sck_q;
  wire m_end  = m_fall & (m_bits == CW'(DW-1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m_busy <= 1'b0; sck_q <= 1'b0; m_div <= '0; m_bits <= '0; m_samp <= 1'b0;
    end else if (!(en & mst)) begin
      m_busy <= 1'b0; sck_q <= 1'b0; m_div <= '0; m_bits <= '0;
    end else if (m_busy) begin
      m_div <= m_tick ? '0 : m_div + DIVW'(1);
      if (m_rise) begin
        sck_q  <= 1'b1;
        m_samp <= miso_i;
      end
      if (m_fall) begin
        sck_q  <= 1'b0;
        m_bits <= m_bits + CW'(1);
        if (m_end) m_busy <= 1'b0;
      end
    end else if (wr_data) begin
      m_busy <= 1'b1; sck_q <= 1'b0; m_div <= '0; m_bits <= '0;
    end

  // slave front end
  logic [1:0]    sck_s, ss_s, mosi_s;
  logic          sck_d, s_hi, s_samp;
  logic [CW-1:0] s_bits;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s <= '0; ss_s <= 2'b11; mosi_s <= '0; sck_d <= 1'b0;
    end else begin
      sck_s  <= {sck_s[0], sck_i};
      ss_s   <= {ss_s[0], ss_n_i};
      mosi_s <= {mosi_s[0], mosi_i};
      sck_d  <= sck_s[1];
    end

  wire s_on     = en & ~mst & ~ss_s[1];
  wire s_rise   = s_on & sck_s[1] & ~sck_d;
  wire s_fall   = s_on & ~sck_s[1] & sck_d;
  wire s_end    = s_fall & (s_bits == CW'(DW-1));
  wire s_active = s_on & ((s_bits != '0) | s_hi);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s_bits <= '0; s_hi <= 1'b0; s_samp <= 1'b0;
    end else if (!s_on) begin
      s_bits <= '0; s_hi <= 1'b0;
    end else begin
      if (s_rise) begin
        s_hi   <= 1'b1;
        s_samp <= mosi_s[1];
      end
      if (s_fall) begin
        s_hi   <= 1'b0;
        s_bits <= s_bits + CW'(1);
      end
    end

  // shared shifter and receive buffer
  wire xfer_busy = mst ? m_busy : s_active;
  wire in_bit    = mst ? m_samp : s_samp;
  wire shift_now = m_fall | s_fall;
  wire xfer_end  = m_end | s_end;
  wire [DW-1:0] shifted = {shreg[DW-2:0], in_bit};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg <= '0; rx_q <= '0;
    end else begin
      if (shift_now) shreg <= shifted;
      else if (wr_data & en & ~xfer_busy) shreg <= bus_wdata;
      if (xfer_end) rx_q <= shifted;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      done_q <= 1'b0; wcol_q <= 1'b0; arm_d <= 1'b0; arm_w <= 1'b0;
    end else begin
      if (xfer_end) done_q <= 1'b1;
      else if (acc_dat & arm_d) done_q <= 1'b0;
      if (wr_data & en & xfer_busy) wcol_q <= 1'b1;
      else if (acc_dat & arm_w) wcol_q <= 1'b0;
      if (rd_stat) begin
        arm_d <= done_q; arm_w <= wcol_q;
      end else if (acc_dat) begin
        arm_d <= 1'b0; arm_w <= 1'b0;
      end
    end

  always_comb
    case (bus_addr)
      2'd0:    bus_rdata = DW'({ie, en, 1'b0, mst, 1'b0, rate});
      2'd1:    bus_rdata = {done_q, wcol_q, {(DW-2){1'b0}}};
      2'd2:    bus_rdata = rx_q;
      default: bus_rdata = '0;
    endcase

  assign irq           = done_q & ie;
  assign sck_o         = sck_q;
  assign mosi_o        = (en & mst) ? shreg[DW-1] : 1'b0;
  assign miso_o        = (en & ~mst) ? shreg[DW-1] : 1'b0;
  assign force_in_miso = en & mst;
  assign force_in_mosi = en & ~mst;
  assign force_in_sck  = en & ~mst;
  assign force_in_ss   = en & ~mst;

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !m_busy |-> !sck_o); // R1
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (m_busy && sck_q && $past(sck_q)) |-> $stable(mosi_o)); // R2
  AST_LAST_BIT_DONE: assert property (@(posedge clk) disable iff (!rst_n) m_end |=> done_q && !m_busy); // R3
  AST_BUSY_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && m_busy) |=> wcol_q); // R6
  AST_BUSY_WRITE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && m_busy && !m_fall) |=> $stable(shreg)); // R6
  AST_DESELECT_HOLDS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mst && ss_s[1]) |=> $stable(rx_q)); // R9
  AST_OVR_ROLES_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(force_in_miso && force_in_mosi)); // R10
endmodule

// File: tb/tb_spi_dual_role.sv
module tb_spi_dual_role;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic irq, sck_o, mosi_o, miso_o;
  logic sck_i = 0, mosi_i = 0, miso_i = 0, ss_n_i = 1;
  logic f_mosi, f_miso, f_sck, f_ss;

  spi_dual_role dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .sck_i(sck_i), .sck_o(sck_o), .mosi_i(mosi_i), .mosi_o(mosi_o),
    .miso_i(miso_i), .miso_o(miso_o), .ss_n_i(ss_n_i),
    .force_in_mosi(f_mosi), .force_in_miso(f_miso), .force_in_sck(f_sck), .force_in_ss(f_ss));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_err = 0;
  task automatic check(input string rq, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_ie, m_en, m_mst, m_busy, m_done, m_wcol, m_armd, m_armw, slave_fin;
  int m_half = 2, tcnt = 0;
  logic [7:0] txb, sbyte;

  always @(posedge clk) if (rst_n) begin
    bit busy_old, fin, dacc, setw, done_old, wcol_old;
    busy_old = m_busy; fin = slave_fin; slave_fin = 0; setw = 0;
    done_old = m_done; wcol_old = m_wcol;
    if (m_busy) begin
      tcnt++;
      if (tcnt == 16*m_half) begin m_busy = 0; fin = 1; end
    end
    dacc = bus_sel && (bus_wr || bus_rd) && bus_addr == 2;
    if (bus_sel && bus_wr && bus_addr == 2 && m_en && m_mst) begin
      if (busy_old) setw = 1;
      else begin m_busy = 1; tcnt = 0; txb = bus_wdata; end
    end
    if (fin) m_done = 1; else if (dacc && m_armd) m_done = 0;
    if (setw) m_wcol = 1; else if (dacc && m_armw) m_wcol = 0;
    if (bus_sel && bus_rd && bus_addr == 1) begin m_armd = done_old; m_armw = wcol_old; end
    else if (dacc) begin m_armd = 0; m_armw = 0; end
    if (bus_sel && bus_wr && bus_addr == 0) begin
      int r;
      m_ie = bus_wdata[7]; m_en = bus_wdata[6]; m_mst = bus_wdata[4];
      r = bus_wdata[2:0]; if (r > 5) r = 5;
      m_half = 2 << r;
    end
  end

  // per-clock comparison and far-end slave data
  always @(negedge clk) if (rst_n) begin
    check("R10 overrides", {f_mosi, f_miso, f_sck, f_ss},
          {m_en && !m_mst, m_en && m_mst, m_en && !m_mst, m_en && !m_mst});
    check("R1 sck", sck_o, m_busy ? ((tcnt / m_half) % 2) : 0);
    check("R4 irq", irq, m_done && m_ie);
    if (m_busy) check("R2 mosi", mosi_o, txb[7 - tcnt/(2*m_half)]);
    miso_i = m_busy ? sbyte[7 - tcnt/(2*m_half)] : 1'b0;
  end

  task automatic bus_op(input bit wr, input logic [1:0] a, input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    bus_sel = 1; bus_wr = wr; bus_rd = !wr; bus_addr = a; bus_wdata = d;
    #1 q = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0; bus_rd = 0;
  endtask
  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    logic [7:0] q; bus_op(1, a, d, q);
  endtask
  task automatic rreg(input logic [1:0] a, input logic [7:0] exp, input string rq);
    logic [7:0] q; bus_op(0, a, 8'h00, q); check(rq, q, exp);
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wait_xfer;
    while (m_busy) @(negedge clk);
    idle(2);
  endtask
  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] far);
    sbyte = far; wreg(2, tx); wait_xfer();
  endtask
  task automatic slave_xfer(input logic [7:0] mb, input bit sel, output logic [7:0] got);
    @(negedge clk); ss_n_i = !sel; idle(8);
    for (int b = 7; b >= 0; b--) begin
      mosi_i = mb[b]; idle(8);
      got[b] = miso_o; sck_i = 1; idle(8);
      sck_i = 0;
    end
    idle(8); ss_n_i = 1; idle(8);
    if (sel) slave_fin = 1;
    idle(2);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] got;
    idle(3); rst_n = 1; idle(2);
    rreg(1, 8'h00, "R3 reset status");
    rreg(0, 8'h00, "R10 reset control");
    check("R4 reset irq", irq, 0);

    // disabled block ignores data writes
    wreg(2, 8'h5A); idle(40);
    rreg(1, 8'h00, "R11 disabled write");
    check("R11 no clock", sck_o, 0);

    // master divide-by-4 with interrupt
    wreg(0, 8'hD0);
    master_xfer(8'hA5, 8'h3C);
    rreg(1, 8'h80, "R3 done set");
    check("R4 irq raised", irq, 1);
    rreg(2, 8'h3C, "R5 received byte");
    rreg(1, 8'h00, "R7 cleared after status+data");

    // data access alone does not clear
    wreg(0, 8'hD3);
    master_xfer(8'h7E, 8'h81);
    rreg(2, 8'h81, "R5 divide-by-32 byte");
    rreg(1, 8'h80, "R7 still set without status read");
    rreg(2, 8'h81, "R7 arming access");
    rreg(1, 8'h00, "R7 cleared");

    // write collision mid-transfer
    wreg(0, 8'h51);
    sbyte = 8'h96; wreg(2, 8'h0F); idle(10);
    wreg(2, 8'hF0); wait_xfer();
    rreg(1, 8'hC0, "R6 collision flagged");
    rreg(2, 8'h96, "R6 transfer intact");
    rreg(1, 8'h00, "R6 R7 both cleared");

    // overrun and double buffering
    wreg(0, 8'h50);
    master_xfer(8'h01, 8'h11);
    master_xfer(8'h02, 8'h22);
    rreg(2, 8'h22, "R8 unread byte overwritten");
    sbyte = 8'h33; wreg(2, 8'h03); idle(12);
    rreg(2, 8'h22, "R8 buffer held during shift");
    wait_xfer();
    rreg(2, 8'h33, "R8 new byte");
    rreg(1, 8'h80, "R3 done");
    rreg(2, 8'h33, "R7 clear access");

    // slowest rate, select 7 clamps to 128
    wreg(0, 8'h57);
    master_xfer(8'h3C, 8'hC3);
    rreg(2, 8'hC3, "R1 clamped rate byte");
    rreg(1, 8'h80, "R3 done slow");
    rreg(2, 8'hC3, "R7 clear slow");

    // the ring: next transfer without a write sends the received byte
    wreg(0, 8'h50);
    sbyte = 8'h5A;
    // shift register now holds 0xC3; start needs a write, so send it explicitly
    master_xfer(8'hC3, 8'h5A);
    rreg(2, 8'h5A, "R5 ring exchange");

    // slave role
    rreg(1, 8'h80, "R3 pre-slave");
    rreg(2, 8'h5A, "R7 pre-slave clear");
    wreg(0, 8'h40);
    wreg(2, 8'h6B);
    slave_xfer(8'hD2, 1, got);
    check("R5 slave sent", got, 8'h6B);
    check("R2 slave msb first", got[7], 0);
    rreg(2, 8'hD2, "R9 slave received");
    rreg(1, 8'h80, "R9 slave done");
    rreg(2, 8'hD2, "R7 slave clear");
    rreg(1, 8'h00, "R7 slave cleared");

    slave_xfer(8'hFF, 0, got);
    rreg(1, 8'h00, "R9 deselected no done");
    rreg(2, 8'hD2, "R9 deselected buffer");
    slave_xfer(8'h24, 1, got);
    check("R5 slave ring", got, 8'hD2);
    rreg(2, 8'h24, "R9 full byte after deselect");

    wreg(0, 8'h00); idle(3);
    check("R10 disabled", {f_mosi, f_miso, f_sck, f_ss}, 4'b0000);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule